// File: doc/BRIEF.md
# Component-Swizzle Vector Lane Unit

This block is a fixed-point datapath that processes one wide word of packed 16-bit two's-complement elements in a single step. The word is split into repeated groups of either two or four elements. Every element of the result belongs to one destination component of its group. Each destination component has its own field set in the control word: an operation code, a source-component select and an operand-component select. In three-address form it also has a two-bit merge mode. The same control fields apply to every group in the word.

In two-address form, a destination component is updated from its own old value and one chosen source component. In three-address form, a chosen source component and a chosen operand component are combined first. The result is then merged into the old destination value by replacing it, negating it, adding it or subtracting it. A component whose operation code is not supported keeps its old destination value and raises an illegal-operation flag. The whole result word is registered, and a one-cycle done pulse marks it one clock after the valid strobe.

Top module: `swz_lane_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `res_o` becomes all zeros and `done_o` and `illegal_o` become 0.
- R2: `done_o` is high for exactly the cycle after each cycle with `valid_i` high. `res_o` changes only after a cycle with `valid_i` high and otherwise holds its value.
- R3: Control bit 41 (the most significant bit) selects the form. 0 is two-address and 1 is three-address. The same field values give different results under the two forms.
- R4: Control bit 40 selects the group size. 0 gives pairs (elements 2j and 2j+1) and 1 gives quads (elements 4j..4j+3). Element 0 sits in bits 15:0 of each word.
- R5: Two-address codes (field bits 3:0) act on the old destination component d and the selected source component s, keeping the low 16 bits. 0010 gives s, 0100 gives d+s, 0101 gives d-s, 0110 gives d*s, 1011 gives d^s, 1100 gives d&s and 1101 gives d|s.
- R6: Three-address codes (field bits 2:0, bit 3 ignored) act on the selected source component s and the selected operand component o, keeping the low 16 bits. 000 gives s+o, 001 gives s-o, 010 gives s*o and 101 gives s|o.
- R7: In three-address form the merge field (field bits 9:8) sets how result t updates the destination component d. 00 gives t, 01 gives 0-t, 10 gives d+t and 11 gives d-t, all modulo 2^16. In two-address form the merge field is ignored.
- R8: The source select (field bits 5:4) and the operand select (field bits 7:6) pick a component index inside the same group. In pair mode only the low bit of each select is used.
- R9: Any other code makes that component keep its old destination value. The unsupported codes include three-address 011 (divide), 100, 110 and 111. `illegal_o` is high with that `done_o` pulse. Legal components of the same word are still computed.
- R10: Destination component k uses the field at control bits 10k+9..10k, for k = 0..3, and every component is written. In pair mode the fields for k = 2 and 3 have no effect, and unsupported codes in those fields do not raise `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Inputs hold a word to process this cycle |
| ctrl_i | input | 42 | Form bit, group-size bit and four per-component field sets |
| src_i | input | 128 | Source word |
| opd_i | input | 128 | Operand word (used in three-address form) |
| dst_i | input | 128 | Old destination word |
| res_o | output | 128 | Registered result word |
| done_o | output | 1 | One-cycle pulse marking a new result |
| illegal_o | output | 1 | An unsupported code was met in the word now reported |

## Verification
Within one word, the illegal-operation path and the normal computation can fall in the same cycle. A single control word may give one destination component an unsupported code, such as the three-address divide, while the other components carry legal operations. The bench builds such mixed words on purpose and also draws random control words, where this happens often. Each word is judged against a behavioural model: the flagged component must come back equal to its old destination value, every other component must carry its computed value, and the flag must appear only together with the done pulse.

// File: rtl/swz_pkg.sv
package swz_pkg;

  // Number of per-component field sets in the control word.
  localparam int NUM_COMP = 4;
  // Width of one per-component field set.
  localparam int COMP_W   = 10;

  // Two-address operation codes.
  localparam logic [3:0] OP2_MOV = 4'b0010;
  localparam logic [3:0] OP2_ADD = 4'b0100;
  localparam logic [3:0] OP2_SUB = 4'b0101;
  localparam logic [3:0] OP2_MUL = 4'b0110;
  localparam logic [3:0] OP2_XOR = 4'b1011;
  localparam logic [3:0] OP2_AND = 4'b1100;
  localparam logic [3:0] OP2_OR  = 4'b1101;

  // Three-address operation codes.
  localparam logic [2:0] OP3_ADD = 3'b000;
  localparam logic [2:0] OP3_SUB = 3'b001;
  localparam logic [2:0] OP3_MUL = 3'b010;
  localparam logic [2:0] OP3_OR  = 3'b101;

  // Merge modes for three-address results.
  localparam logic [1:0] MRG_REPL = 2'b00;
  localparam logic [1:0] MRG_NEG  = 2'b01;
  localparam logic [1:0] MRG_ADD  = 2'b10;
  localparam logic [1:0] MRG_SUB  = 2'b11;

  typedef enum logic [2:0] {
    ALU_MOV,
    ALU_ADD,
    ALU_SUB,
    ALU_MUL,
    ALU_XOR,
    ALU_AND,
    ALU_OR
  } alu_op_t;

  // One destination component's field set, MSB first.
  typedef struct packed {
    logic [1:0] merge;
    logic [1:0] osel;
    logic [1:0] ssel;
    logic [3:0] code;
  } comp_ctrl_t;

endpackage

// File: rtl/swz_decode.sv
module swz_decode
  import swz_pkg::*;
(
  input  logic       three_addr,
  input  logic [3:0] code,
  output alu_op_t    alu_op,
  output logic       legal
);

  always_comb begin
    legal  = 1'b1;
    alu_op = ALU_MOV;
    if (three_addr) begin
      case (code[2:0])
        OP3_ADD: alu_op = ALU_ADD;
        OP3_SUB: alu_op = ALU_SUB;
        OP3_MUL: alu_op = ALU_MUL;
        OP3_OR:  alu_op = ALU_OR;
        default: legal  = 1'b0;
      endcase
    end else begin
      case (code)
        OP2_MOV: alu_op = ALU_MOV;
        OP2_ADD: alu_op = ALU_ADD;
        OP2_SUB: alu_op = ALU_SUB;
        OP2_MUL: alu_op = ALU_MUL;
        OP2_XOR: alu_op = ALU_XOR;
        OP2_AND: alu_op = ALU_AND;
        OP2_OR:  alu_op = ALU_OR;
        default: legal  = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/swz_alu.sv
module swz_alu
  import swz_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_t      op,
  input  logic         three_addr,
  input  logic [1:0]   merge,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] dst,
  output logic [W-1:0] y
);

  logic [W-1:0] core;

  // Operand a is the old destination (two-address) or the source (three-address).
  always_comb begin
    case (op)
      ALU_MOV: core = b;
      ALU_ADD: core = a + b;
      ALU_SUB: core = a - b;
      ALU_MUL: core = a * b;
      ALU_XOR: core = a ^ b;
      ALU_AND: core = a & b;
      ALU_OR:  core = a | b;
      default: core = b;
    endcase
  end

  always_comb begin
    if (!three_addr) begin
      y = core;
    end else begin
      case (merge)
        MRG_REPL: y = core;
        MRG_NEG:  y = '0 - core;
        MRG_ADD:  y = dst + core;
        MRG_SUB:  y = dst - core;
        default:  y = core;
      endcase
    end
  end

endmodule

// File: rtl/swz_lane.sv
module swz_lane
  import swz_pkg::*;
#(
  parameter int W   = 16,
  parameter int GRP = 4
) (
  input  logic             three_addr,
  input  logic             quad,
  input  comp_ctrl_t       cc,
  input  logic [GRP*W-1:0] src_grp,
  input  logic [GRP*W-1:0] opd_grp,
  input  logic [W-1:0]     dst_e,
  output logic [W-1:0]     y,
  output logic             ill
);

  logic [1:0]   ssel_eff;
  logic [1:0]   osel_eff;
  logic [W-1:0] s_val;
  logic [W-1:0] o_val;
  logic [W-1:0] a_val;
  logic [W-1:0] b_val;
  logic [W-1:0] alu_y;
  alu_op_t      op;
  logic         legal;

  // In pair mode only the low select bit addresses the group.
  assign ssel_eff = quad ? cc.ssel : {1'b0, cc.ssel[0]};
  assign osel_eff = quad ? cc.osel : {1'b0, cc.osel[0]};

  assign s_val = src_grp[ssel_eff*W +: W];
  assign o_val = opd_grp[osel_eff*W +: W];

  assign a_val = three_addr ? s_val : dst_e;
  assign b_val = three_addr ? o_val : s_val;

  swz_decode u_dec (
    .three_addr (three_addr),
    .code       (cc.code),
    .alu_op     (op),
    .legal      (legal)
  );

  swz_alu #(.W(W)) u_alu (
    .op         (op),
    .three_addr (three_addr),
    .merge      (cc.merge),
    .a          (a_val),
    .b          (b_val),
    .dst        (dst_e),
    .y          (alu_y)
  );

  assign y   = legal ? alu_y : dst_e;
  assign ill = ~legal;

endmodule

// File: rtl/swz_lane_unit.sv
module swz_lane_unit
  import swz_pkg::*;
#(
  parameter  int ELEM_W   = 16,
  parameter  int NUM_ELEM = 8,   // must be a multiple of 4
  localparam int DATA_W   = ELEM_W * NUM_ELEM,
  localparam int CTRL_W   = 2 + NUM_COMP * COMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] opd_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o,
  output logic              done_o,
  output logic              illegal_o
);

  localparam int FMT_BIT  = CTRL_W - 1;
  localparam int QUAD_BIT = CTRL_W - 2;
  localparam int WIN_W    = NUM_COMP * ELEM_W;

  logic                three_addr;
  logic                quad;
  logic [DATA_W-1:0]   next_res;
  logic [NUM_ELEM-1:0] lane_ill;

  assign three_addr = ctrl_i[FMT_BIT];
  assign quad       = ctrl_i[QUAD_BIT];

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
    localparam int QBASE = (e / 4) * 4;
    localparam int PBASE = (e / 2) * 2;
    localparam int KQ    = e % 4;
    localparam int KP    = e % 2;

    logic [WIN_W-1:0] src_win;
    logic [WIN_W-1:0] opd_win;
    comp_ctrl_t       cc;

    // Pair windows repeat the pair so that the upper half is never out of range.
    assign src_win = quad ? src_i[QBASE*ELEM_W +: WIN_W]
                          : {2{src_i[PBASE*ELEM_W +: 2*ELEM_W]}};
    assign opd_win = quad ? opd_i[QBASE*ELEM_W +: WIN_W]
                          : {2{opd_i[PBASE*ELEM_W +: 2*ELEM_W]}};
    assign cc      = quad ? comp_ctrl_t'(ctrl_i[KQ*COMP_W +: COMP_W])
                          : comp_ctrl_t'(ctrl_i[KP*COMP_W +: COMP_W]);

    swz_lane #(.W(ELEM_W), .GRP(NUM_COMP)) u_lane (
      .three_addr (three_addr),
      .quad       (quad),
      .cc         (cc),
      .src_grp    (src_win),
      .opd_grp    (opd_win),
      .dst_e      (dst_i[e*ELEM_W +: ELEM_W]),
      .y          (next_res[e*ELEM_W +: ELEM_W]),
      .ill        (lane_ill[e])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= valid_i;
      illegal_o <= valid_i & (|lane_ill);
      if (valid_i) begin
        res_o <= next_res;
      end
    end
  end

endmodule

// File: rtl/swz_lane_unit_chk.sv
module swz_lane_unit_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [DATA_W-1:0] res_o,
  input logic              done_o,
  input logic              illegal_o
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !done_o && !illegal_o)); // R1

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> done_o); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !done_o); // R2

  AST_RES_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(res_o)); // R2

  AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> done_o); // R9

endmodule

bind swz_lane_unit swz_lane_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid_i   (valid_i),
  .res_o     (res_o),
  .done_o    (done_o),
  .illegal_o (illegal_o)
);

// File: tb/swz_lane_unit_tb.sv
module swz_lane_unit_tb;

  localparam int EW = 16;
  localparam int NE = 8;
  localparam int DW = EW * NE;
  localparam int CW = 42;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_i = 1'b0;
  logic [CW-1:0] ctrl_i = '0;
  logic [DW-1:0] src_i = '0;
  logic [DW-1:0] opd_i = '0;
  logic [DW-1:0] dst_i = '0;
  logic [DW-1:0] res_o;
  logic          done_o;
  logic          illegal_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DW-1:0] exp_res = '0;
  bit            exp_done = 0;
  bit            exp_ill = 0;
  string         cur_req = "R1";

  always #5 clk = ~clk;

  swz_lane_unit u_dut (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .ctrl_i    (ctrl_i),
    .src_i     (src_i),
    .opd_i     (opd_i),
    .dst_i     (dst_i),
    .res_o     (res_o),
    .done_o    (done_o),
    .illegal_o (illegal_o)
  );

  function automatic logic [9:0] fld(input int code, input int ss, input int os, input int mg);
    logic [9:0] f;
    f[3:0] = code[3:0];
    f[5:4] = ss[1:0];
    f[7:6] = os[1:0];
    f[9:8] = mg[1:0];
    return f;
  endfunction

  function automatic logic [CW-1:0] mk(input bit three, input bit quad,
                                       input logic [9:0] f0, input logic [9:0] f1,
                                       input logic [9:0] f2, input logic [9:0] f3);
    return {three, quad, f3, f2, f1, f0};
  endfunction

  // Behavioural reference: element-by-element evaluation.
  function automatic void model(input logic [CW-1:0] c, input logic [DW-1:0] s,
                                input logic [DW-1:0] o, input logic [DW-1:0] d,
                                output logic [DW-1:0] r, output bit ill);
    int gs;
    bit three;
    gs    = c[40] ? 4 : 2;
    three = c[41];
    ill   = 0;
    r     = '0;
    for (int e = 0; e < NE; e++) begin
      int k, base, ss, os;
      logic [9:0]  f;
      logic [15:0] sv, ov, dv;
      logic [15:0] t;
      bit ok;
      k    = e % gs;
      base = e - k;
      f    = c[k*10 +: 10];
      ss   = int'(f[5:4]) % gs;
      os   = int'(f[7:6]) % gs;
      sv   = s[(base+ss)*EW +: EW];
      ov   = o[(base+os)*EW +: EW];
      dv   = d[e*EW +: EW];
      ok   = 1;
      t    = '0;
      if (three) begin
        case (f[2:0])
          3'd0: t = sv + ov;
          3'd1: t = sv - ov;
          3'd2: t = sv * ov;
          3'd5: t = sv | ov;
          default: ok = 0;
        endcase
        case (f[9:8])
          2'd1: t = 16'd0 - t;
          2'd2: t = dv + t;
          2'd3: t = dv - t;
          default: ;
        endcase
      end else begin
        case (f[3:0])
          4'd2:  t = sv;
          4'd4:  t = dv + sv;
          4'd5:  t = dv - sv;
          4'd6:  t = dv * sv;
          4'd11: t = dv ^ sv;
          4'd12: t = dv & sv;
          4'd13: t = dv | sv;
          default: ok = 0;
        endcase
      end
      r[e*EW +: EW] = ok ? t : dv;
      if (!ok) ill = 1;
    end
  endfunction

  task automatic compare();
    checks++;
    if (res_o !== exp_res) begin
      errors++;
      $display("FAIL %s res_o actual=%h expected=%h", cur_req, res_o, exp_res);
    end
    checks++;
    if (done_o !== exp_done) begin
      errors++;
      $display("FAIL %s done_o actual=%b expected=%b", cur_req, done_o, exp_done);
    end
    checks++;
    if (illegal_o !== exp_ill) begin
      errors++;
      $display("FAIL %s illegal_o actual=%b expected=%b", cur_req, illegal_o, exp_ill);
    end
  endtask

  // Check the outputs from the previous edge, then drive the next inputs.
  task automatic step(input bit v, input logic [CW-1:0] c, input logic [DW-1:0] s,
                      input logic [DW-1:0] o, input logic [DW-1:0] d, input string req);
    logic [DW-1:0] r;
    bit ill;
    @(negedge clk);
    compare();
    rst     = 1'b0;
    valid_i = v;
    ctrl_i  = c;
    src_i   = s;
    opd_i   = o;
    dst_i   = d;
    cur_req = req;
    model(c, s, o, d, r, ill);
    exp_done = v;
    exp_ill  = v & ill;
    if (v) exp_res = r;
  endtask

  task automatic do_reset(input bit v);
    @(negedge clk);
    compare();
    rst      = 1'b1;
    valid_i  = v;
    cur_req  = "R1";
    exp_res  = '0;
    exp_done = 0;
    exp_ill  = 0;
  endtask

  function automatic logic [DW-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  logic [DW-1:0] S = 128'h0008_0007_0006_0005_0004_0003_0002_0001;
  logic [DW-1:0] O = 128'h0080_0070_0060_0050_0040_0030_0020_0010;
  logic [DW-1:0] D = 128'h0800_0700_0600_0500_0400_0300_0200_0100;
  logic [DW-1:0] idw = 128'h0000_0000_0000_0000_0000_0000_0000_0000;

  initial begin
    int two_codes [7] = '{2, 4, 5, 6, 11, 12, 13};
    int three_codes [4] = '{0, 1, 2, 5};
    repeat (3) @(posedge clk);
    // R1: reset state observed at the first step
    step(0, '0, '0, '0, '0, "R2");
    // R4 R8: quad reverse move
    step(1, mk(0, 1, fld(2,3,0,0), fld(2,2,0,0), fld(2,1,0,0), fld(2,0,0,0)), S, O, D, "R8");
    // R4 R10: pair swap, upper fields illegal but ignored
    step(1, mk(0, 0, fld(2,1,0,0), fld(2,0,0,0), fld(0,0,0,0), fld(15,0,0,0)), S, O, D, "R10");
    // R8: pair mode uses only the low select bit
    step(1, mk(0, 0, fld(2,2,0,0), fld(2,3,0,0), fld(2,0,0,0), fld(2,0,0,0)), S, O, D, "R8");
    // R5: every two-address code
    foreach (two_codes[i])
      step(1, mk(0, 1, fld(two_codes[i],1,0,0), fld(two_codes[i],0,0,0),
                 fld(two_codes[i],3,0,0), fld(two_codes[i],2,0,0)), S, O, D, "R5");
    // R6: every three-address code, replace merge, bit 3 set on one field
    foreach (three_codes[i])
      step(1, mk(1, 1, fld(three_codes[i],0,1,0), fld(three_codes[i]+8,2,3,0),
                 fld(three_codes[i],3,3,0), fld(three_codes[i],1,0,0)), S, O, D, "R6");
    // R7: every merge mode
    for (int m = 0; m < 4; m++)
      step(1, mk(1, 0, fld(2,1,0,m), fld(1,0,1,m), fld(0,0,0,0), fld(0,0,0,0)), S, O, D, "R7");
    // R7: merge field ignored in two-address form
    step(1, mk(0, 1, fld(4,0,0,3), fld(4,1,0,1), fld(4,2,0,2), fld(4,3,0,3)), S, O, D, "R7");
    // R3: identical fields, both forms
    step(1, mk(0, 1, fld(5,1,2,2), fld(6,2,1,0), fld(13,3,0,1), fld(2,0,3,3)), S, O, D, "R3");
    step(1, mk(1, 1, fld(5,1,2,2), fld(6,2,1,0), fld(13,3,0,1), fld(2,0,3,3)), S, O, D, "R3");
    // R9: divide in one component, others legal
    step(1, mk(1, 1, fld(0,0,0,0), fld(3,1,1,0), fld(2,2,2,2), fld(5,3,3,3)), S, O, D, "R9");
    step(1, mk(0, 0, fld(4,0,0,0), fld(0,0,0,0), fld(2,0,0,0), fld(2,0,0,0)), S, O, D, "R9");
    // R5 wrap: overflow keeps low bits
    step(1, mk(0, 1, fld(4,0,0,0), fld(6,1,0,0), fld(5,2,0,0), fld(6,3,0,0)),
         128'h7fff_0100_0001_7fff_ffff_8000_0100_0001,
         O, 128'h0001_0100_8000_0001_ffff_0002_0100_7fff, "R5");
    // R2: idle cycles hold result
    step(0, '0, rnd(), rnd(), rnd(), "R2");
    step(0, mk(0, 1, fld(2,0,0,0), fld(2,0,0,0), fld(2,0,0,0), fld(2,0,0,0)), rnd(), idw, idw, "R2");
    // R1: reset while valid is high
    do_reset(1);
    step(0, '0, '0, '0, '0, "R2");
    // Random mix, legal and illegal codes, random valid
    for (int n = 0; n < 400; n++) begin
      logic [CW-1:0] c;
      c = {$urandom, $urandom};
      step(($urandom % 4) != 0, c, rnd(), rnd(), rnd(),
           c[40] ? (c[41] ? "R6" : "R5") : "R4");
    end
    step(0, '0, '0, '0, '0, "R2");
    @(negedge clk);
    compare();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule